// File: doc/BRIEF.md
# DMA Remapping Fault Recorder

This block sits beside an address-translation walker in an I/O remapping unit. Whenever the walker blocks a device request, it presents a one-cycle fault event. The event carries the requester identity (bus/device/function), the access direction, the untranslated I/O virtual address and a reason code. The recorder stores the event in one of a small ring of fault records. One clock later it tells the requester path to answer the blocked request with an Unsupported Request completion.

Host software reads the records through a word-addressed register port and acknowledges each record by writing 1 to its valid bit. A level interrupt stays high while any record is still valid or while the sticky overflow flag is set. When every record is occupied, a further fault is not stored and sets the overflow flag instead. That fault still produces its Unsupported Request response.

Top module: `dma_fault_recorder`

## Requirements
- R1: A fault event arriving while at least one record is free is stored in one free record at the next clock edge. The record's status word (word 0) holds the valid flag in bit 0, the direction in bit 1 (1 = write), the reason in bits 15:8 and the bus/device/function in bits 31:16. Word 1 holds IOVA bits 31:0 and word 2 holds IOVA bits 63:32. Record k occupies register addresses 4k to 4k+3.
- R2: The record chosen is the first free one found when scanning upward, with wrap-around, from the slot that follows the most recently filled slot. After reset the scan starts at slot 0.
- R3: A fault event arriving while all records are valid changes no record and sets the overflow flag, which is bit 0 of the status register at address 4·NREC.
- R4: A write with data bit 0 = 1 to a record's status word clears its valid flag. A write with bit 0 = 0, a write to any other word, or a write to a free record has no effect.
- R5: The overflow flag stays set until a write with bit 0 = 1 to address 4·NREC clears it. If an overflowing fault arrives in the same cycle as that write, the flag remains set.
- R6: `irq` is high exactly when at least one record is valid or the overflow flag is set.
- R7: For every fault event, whether stored or dropped, `ur_valid` is high for exactly the following cycle, and `ur_bdf` then carries that event's requester identity.
- R8: After reset, every register reads 0, `irq` is low and `ur_valid` is low.
- R9: Reads of addresses that map to no register (word 3 of a record, words 1 to 3 of the status block, and anything above it) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flt_valid | input | 1 | One-cycle fault event from the translation walker |
| flt_bdf | input | 16 | Requester bus/device/function |
| flt_write | input | 1 | 1 when the blocked access was a write |
| flt_iova | input | 64 | Faulting I/O virtual address |
| flt_reason | input | 8 | Fault reason code |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Level interrupt to the host |
| ur_valid | output | 1 | Request path must return Unsupported Request |
| ur_bdf | output | 16 | Requester the Unsupported Request is addressed to |

## Verification
The assertions watch every cycle for four things: each fault producing its Unsupported Request and an interrupt one cycle later, a full ring dropping the event and setting overflow, a capture adding exactly one valid record, and the slot picker granting at most one slot and never an occupied one. Only the bench scenarios can show the rotating order in which slots are filled, the exact field placement in the readable words, and the effect of acknowledgements that are ignored. The same holds for an overflow clear racing a new overflow and for reads of unmapped addresses. These are compared word by word against a reference model.

// File: rtl/frec_pkg.sv
// Package: shared constants and the stored fault-record type.
// Assumes: register words are 32 bits and an IOVA fits in 64 bits.
package frec_pkg;
    localparam int BDF_W      = 16;
    localparam int RSN_W      = 8;
    localparam int IOVA_W_MAX = 64;
    localparam int REG_DW     = 32;

    localparam logic [1:0] W_STAT = 2'd0;
    localparam logic [1:0] W_ALO  = 2'd1;
    localparam logic [1:0] W_AHI  = 2'd2;

    typedef struct packed {
        logic [BDF_W-1:0]      bdf;
        logic                  is_wr;
        logic [RSN_W-1:0]      reason;
        logic [IOVA_W_MAX-1:0] iova;
    } frec_t;
endpackage

// File: rtl/frec_slot_pick.sv
// Slot picker: finds the first free record, scanning upward from `head`
// with wrap-around. It gives a one-hot grant and the slot index.
// Assumes: head < N; purely combinational.
module frec_slot_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  busy,
    input  logic [IW-1:0] head,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] slot,
    output logic          any_free
);
    // Rotating first-free scan starting at head.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        slot  = '0;
        for (int k = 0; k < N; k++) begin
            if (!found && !busy[(int'(head) + k) % N]) begin
                found = 1'b1;
                grant[(int'(head) + k) % N] = 1'b1;
                slot = IW'((int'(head) + k) % N);
            end
        end
    end

    assign any_free = ~&busy;
endmodule

// File: rtl/frec_bank.sv
// Record bank: N fault records, each with a valid flag. A capture grant
// loads the record and sets its valid flag; a clear drops the valid flag.
// Assumes: capture is only granted to a slot whose valid flag is low.
module frec_bank
    import frec_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        cap,
    input  frec_t               din,
    input  logic [N-1:0]        clr,
    output logic [N-1:0]        valid,
    output frec_t [N-1:0]       recs
);
    for (genvar i = 0; i < N; i++) begin : g_rec
        // Load, hold or acknowledge one record.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[i] <= 1'b0;
                recs[i]  <= '0;
            end else if (cap[i]) begin
                valid[i] <= 1'b1;
                recs[i]  <= din;
            end else if (clr[i]) begin
                valid[i] <= 1'b0;
            end
        end
    end

    // R1: a capture with no acknowledge in the same cycle adds one valid record.
    a_r1_capture_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (|cap && !(|clr)) |=> $countones(valid) == $past($countones(valid)) + 1);
endmodule

// File: rtl/frec_readmux.sv
// Read mux: maps the word address onto record fields and the overflow
// status. Unmapped words read 0.
// Assumes: address = {index, word[1:0]}; index N selects the status block.
module frec_readmux
    import frec_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 5
) (
    input  logic [AW-1:0]     addr,
    input  logic [N-1:0]      valid,
    input  frec_t [N-1:0]     recs,
    input  logic              ovf,
    output logic [REG_DW-1:0] rdata
);
    logic [AW-3:0] idx;
    logic [1:0]    word;

    assign idx  = addr[AW-1:2];
    assign word = addr[1:0];

    // Select the addressed word.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (int'(idx) == i) begin
                case (word)
                    W_STAT:  rdata = {recs[i].bdf, recs[i].reason, 6'b0,
                                      recs[i].is_wr, valid[i]};
                    W_ALO:   rdata = recs[i].iova[31:0];
                    W_AHI:   rdata = recs[i].iova[63:32];
                    default: rdata = '0;
                endcase
            end
        end
        if (int'(idx) == N && word == W_STAT) begin
            rdata = {31'b0, ovf};
        end
    end
endmodule

// File: rtl/dma_fault_recorder.sv
// Fault recorder top. Stores translation faults in a ring of NREC records
// and sets a sticky overflow when the ring is full. Raises a level
// interrupt and issues an Unsupported Request response one cycle after
// every fault.
// Assumes: flt_valid is a single-cycle event per blocked request;
// ADDR_W <= 64.
module dma_fault_recorder
    import frec_pkg::*;
#(
    parameter int NREC   = 4,
    parameter int ADDR_W = 64,
    localparam int REG_AW = $clog2(NREC + 1) + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flt_valid,
    input  logic [BDF_W-1:0]    flt_bdf,
    input  logic                flt_write,
    input  logic [ADDR_W-1:0]   flt_iova,
    input  logic [RSN_W-1:0]    flt_reason,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [REG_DW-1:0]   reg_wdata,
    output logic [REG_DW-1:0]   reg_rdata,
    output logic                irq,
    output logic                ur_valid,
    output logic [BDF_W-1:0]    ur_bdf
);
    localparam int IW = (NREC > 1) ? $clog2(NREC) : 1;

    logic [NREC-1:0]   valid;
    frec_t [NREC-1:0]  recs;
    logic [NREC-1:0]   grant;
    logic [NREC-1:0]   cap;
    logic [NREC-1:0]   clr;
    logic [IW-1:0]     slot;
    logic [IW-1:0]     head;
    logic              any_free;
    logic              ovf;
    logic              ovf_clr;
    frec_t             din;

    frec_slot_pick #(.N(NREC), .IW(IW)) i_pick (
        .busy(valid), .head(head), .grant(grant),
        .slot(slot), .any_free(any_free)
    );

    assign cap = flt_valid ? grant : '0;
    assign din = '{bdf: flt_bdf, is_wr: flt_write, reason: flt_reason,
                   iova: IOVA_W_MAX'(flt_iova)};

    // Write-1-to-clear decode per record status word.
    for (genvar i = 0; i < NREC; i++) begin : g_clr
        assign clr[i] = reg_wr && reg_wdata[0] && (reg_addr == REG_AW'(i * 4));
    end
    assign ovf_clr = reg_wr && reg_wdata[0] && (reg_addr == REG_AW'(NREC * 4));

    frec_bank #(.N(NREC)) i_bank (
        .clk(clk), .rst_n(rst_n), .cap(cap), .din(din),
        .clr(clr), .valid(valid), .recs(recs)
    );

    frec_readmux #(.N(NREC), .AW(REG_AW)) i_rmux (
        .addr(reg_addr), .valid(valid), .recs(recs),
        .ovf(ovf), .rdata(reg_rdata)
    );

    // Sticky overflow: a new overflow wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ovf <= 1'b0;
        else if (flt_valid && !any_free) ovf <= 1'b1;
        else if (ovf_clr)                ovf <= 1'b0;
    end

    // Ring head: the slot after the most recently filled one.
    always_ff @(posedge clk) begin
        if (!rst_n)                     head <= '0;
        else if (flt_valid && any_free) head <= (int'(slot) == NREC - 1) ? '0 : slot + 1'b1;
    end

    // Unsupported Request response, one cycle after each fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ur_valid <= 1'b0;
            ur_bdf   <= '0;
        end else begin
            ur_valid <= flt_valid;
            if (flt_valid) ur_bdf <= flt_bdf;
        end
    end

    assign irq = (|valid) || ovf;

    // R7: every fault gets an Unsupported Request for its requester.
    a_r7_ur_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> ur_valid && ur_bdf == $past(flt_bdf));
    // R6: every fault leaves the interrupt raised.
    a_r6_irq_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> irq);
    // R3: a full ring drops the event and keeps all records.
    a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && &valid && !(|clr)) |=> &valid && ovf);
    // R5: overflow set wins over a same-cycle clear.
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && &valid) |=> ovf);
    // R2: at most one slot granted, never an occupied one.
    a_r2_single_free_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & valid) == '0));
endmodule

// File: tb/test_dma_fault_recorder.sv
module test_dma_fault_recorder;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flt_valid = 1'b0;
    logic [15:0] flt_bdf = '0;
    logic        flt_write = 1'b0;
    logic [63:0] flt_iova = '0;
    logic [7:0]  flt_reason = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        ur_valid;
    logic [15:0] ur_bdf;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference model
    logic        mv[N];
    logic        mwr[N];
    logic [15:0] mbdf[N];
    logic [7:0]  mrsn[N];
    logic [63:0] miova[N];
    logic        movf;
    int          mhead;

    always #4 clk = ~clk;

    dma_fault_recorder i_dma_fault_recorder (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_bdf(flt_bdf),
        .flt_write(flt_write), .flt_iova(flt_iova), .flt_reason(flt_reason),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .ur_valid(ur_valid), .ur_bdf(ur_bdf)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(int i, int w);
        if (i < N) begin
            case (w)
                0: return {mbdf[i], mrsn[i], 6'b0, mwr[i], mv[i]};
                1: return miova[i][31:0];
                2: return miova[i][63:32];
                default: return 32'h0;
            endcase
        end
        if (i == N && w == 0) return {31'b0, movf};
        return 32'h0;
    endfunction

    function automatic bit model_any_valid();
        for (int i = 0; i < N; i++) if (mv[i]) return 1'b1;
        return movf;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            mv[i] = 0; mwr[i] = 0; mbdf[i] = 0; mrsn[i] = 0; miova[i] = 0;
        end
        movf = 0;
        mhead = 0;
    endtask

    // update model with the inputs applied at the last edge
    task automatic model_step(bit fv, logic [15:0] b, bit w, logic [63:0] a,
                              logic [7:0] r, bit we, logic [4:0] wa, logic [31:0] wd);
        bit full = 1'b1;
        int pick = -1;
        for (int i = 0; i < N; i++) if (!mv[i]) full = 1'b0;
        if (fv && !full) begin
            for (int k = 0; k < N; k++)
                if (pick < 0 && !mv[(mhead + k) % N]) pick = (mhead + k) % N;
        end
        if (we && wd[0]) begin
            for (int i = 0; i < N; i++) if (wa == 5'(i * 4)) mv[i] = 0;
        end
        if (pick >= 0) begin
            mv[pick] = 1; mwr[pick] = w; mbdf[pick] = b;
            mrsn[pick] = r; miova[pick] = a;
            mhead = (pick + 1) % N;
        end
        if (fv && full) movf = 1;
        else if (we && wd[0] && wa == 5'(N * 4)) movf = 0;
    endtask

    task automatic check_regs(string req);
        for (int i = 0; i < 8; i++) begin
            for (int w = 0; w < 4; w++) begin
                reg_addr = 5'(i * 4 + w);
                #0.1;
                chk(req, $sformatf("rdata@%0d", i * 4 + w), 64'(reg_rdata), 64'(exp_word(i, w)));
            end
        end
    endtask

    // one clock with the given inputs, then check everything
    task automatic op(string req, bit fv, logic [15:0] b, bit w, logic [63:0] a,
                      logic [7:0] r, bit we, logic [4:0] wa, logic [31:0] wd);
        flt_valid = fv; flt_bdf = b; flt_write = w; flt_iova = a; flt_reason = r;
        reg_wr = we; reg_addr = wa; reg_wdata = wd;
        @(posedge clk);
        #1;
        flt_valid = 0; reg_wr = 0;
        model_step(fv, b, w, a, r, we, wa, wd);
        chk("R7", "ur_valid", 64'(ur_valid), 64'(fv));
        if (fv) chk("R7", "ur_bdf", 64'(ur_bdf), 64'(b));
        chk("R6", "irq", 64'(irq), 64'(model_any_valid()));
        check_regs(req);
    endtask

    task automatic fault(string req, logic [15:0] b, bit w, logic [63:0] a, logic [7:0] r);
        op(req, 1, b, w, a, r, 0, 5'd0, 32'd0);
    endtask

    task automatic wreg(string req, logic [4:0] wa, logic [31:0] wd);
        op(req, 0, 16'd0, 0, 64'd0, 8'd0, 1, wa, wd);
    endtask

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R8: reset state
        chk("R8", "irq", 64'(irq), 64'd0);
        chk("R8", "ur_valid", 64'(ur_valid), 64'd0);
        check_regs("R8 R9");

        // R1 R2: fill slots 0..3 in order
        fault("R1 R2", 16'h0108, 1'b0, 64'hDEAD_BEEF_1000_0000, 8'h05);
        fault("R1 R2", 16'h02A1, 1'b1, 64'h0000_0001_FFC0_0000, 8'h06);
        fault("R1 R2", 16'hFFFF, 1'b0, 64'hFFFF_FFFF_FFFF_F000, 8'hFF);
        fault("R1 R2", 16'h0000, 1'b1, 64'h0000_0000_0000_0000, 8'h01);
        // R3: full ring drops and sets overflow, UR still issued
        fault("R3", 16'h1234, 1'b1, 64'h1111_2222_3333_4444, 8'h22);
        // R4: clearing slot 2
        wreg("R4", 5'd8, 32'h0000_0001);
        // R4: write 0 to valid bit, writes to address words, clear of free slot
        wreg("R4", 5'd0, 32'hFFFF_FFFE);
        wreg("R4", 5'd1, 32'hFFFF_FFFF);
        wreg("R4", 5'd8, 32'h0000_0001);
        // R2: next fault goes to slot 2 (first free at or after head 0)
        fault("R2", 16'h0A0B, 1'b0, 64'h0000_ABCD_0000_1234, 8'h09);
        // R5: overflow clear racing a new overflow keeps flag set
        op("R5", 1, 16'h0C0D, 1'b0, 64'h55, 8'h33, 1, 5'd16, 32'h1);
        // R5: plain overflow clear
        wreg("R5", 5'd16, 32'h1);
        // R6: drain everything, interrupt drops
        for (int i = 0; i < N; i++) wreg("R4 R6", 5'(i * 4), 32'h1);
        // R2: after drain, head continues at slot 3
        fault("R2", 16'h0E0F, 1'b1, 64'h77, 8'h44);

        // random mix
        for (int n = 0; n < 600; n++) begin
            int kind;
            bit fv, we;
            logic [4:0] wa;
            kind = $urandom_range(0, 9);
            fv = (kind < 5) || (kind == 9);
            we = (kind >= 5);
            wa = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 31))
                                             : 5'($urandom_range(0, N) * 4);
            op("R1 R2 R3 R4 R5 R9", fv, 16'($urandom), 1'($urandom),
               {32'($urandom), 32'($urandom)}, 8'($urandom), we, wa, 32'($urandom));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule